// File: doc/BRIEF.md
# Sample FIFO with Threshold Interrupt

This block sits between a data converter and a host. The acquisition side pushes one sample per strobe into an on-chip buffer. The host pulls the samples back in arrival order through a read strobe. The usable depth is 512 samples in the normal mode and 1024 samples when the extended mode input is high. It can change at run time without losing stored data.

The host programs a fill threshold through two narrow register writes. The low write carries threshold bits 8:1. The high write carries bit 9 in its data bit 0. Threshold bit 0 is always zero, so the value written is half the requested count. Four flags report the state of the buffer: empty, at-or-above threshold, full, and a sticky overflow. A latched interrupt request is raised from one of three sources, chosen by the buffer-enable and scan-enable bits: the threshold being reached, a complete channel scan, or each stored sample. In scan mode the busy output stays high from the start command until samples for every channel from the low to the high channel number have arrived.

Top module: `sample_fifo_irq`

## Requirements
- R1: The threshold is {hi bit, lo byte, 0}, where hi bit is bit 0 of the data on a high-register write. `thr_hit` is high when the fill level is nonzero and at or above the threshold. A threshold of 0 therefore behaves like a threshold of 1.
- R2: `empty` is high exactly when the fill level is 0. A read strobe while empty returns 16'h00FF on `rd_data` in the following cycle and leaves the level unchanged.
- R3: Samples come back in the order they were accepted. `rd_data` holds the oldest sample in the cycle after the `rd_req` cycle.
- R4: `full` is high when the level is at or above the active depth. A write while full is dropped and the level does not change.
- R5: A write while full sets `ovf`. `ovf` stays set until a read of a non-empty buffer. If an overflowing write and such a read fall in the same cycle, `ovf` remains set.
- R6: The active depth is 512 when `enh_mode` is 0 and 1024 when it is 1.
- R7: A `fifo_rst` pulse leaves `empty`=1, `thr_hit`=0, `full`=0 and `ovf`=0 after the edge. A write in the same cycle is discarded.
- R8: With `fifo_en`=1, `irq` is set at the edge that ends the first cycle in which `thr_hit` is seen high after having been low. This is one cycle after `thr_hit` rises.
- R9: With `fifo_en`=0 and `scan_en`=0, every accepted write sets `irq` at the same edge. With `fifo_en`=0 and `scan_en`=1, `irq` is set at the edge that completes a scan.
- R10: `irq` stays high until an `irq_clr` cycle. When a set event and `irq_clr` fall in the same cycle, the set wins.
- R11: With `scan_en`=1, a `conv_start` while idle raises `busy`. `busy` stays high until ((hi_chan-lo_chan) mod 32)+1 sample strobes have been seen, and drops at the edge of the last one. With `scan_en`=0, `busy` follows `conv_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Sample strobe from the converter side |
| wr_data | input | 16 | Sample value |
| rd_req | input | 1 | Host read strobe |
| rd_data | output | 16 | Read result, valid the cycle after `rd_req` |
| thr_lo_we | input | 1 | Write threshold bits 8:1 from `thr_wdata` |
| thr_hi_we | input | 1 | Write threshold bit 9 from `thr_wdata[0]` |
| thr_wdata | input | 8 | Threshold write data |
| fifo_en | input | 1 | Threshold interrupt source select |
| scan_en | input | 1 | Scan mode |
| enh_mode | input | 1 | Extended depth |
| fifo_rst | input | 1 | Buffer clear pulse |
| lo_chan | input | 5 | First channel of a scan |
| hi_chan | input | 5 | Last channel of a scan |
| conv_start | input | 1 | Start of conversion or scan |
| conv_busy | input | 1 | Converter busy status, passed through outside scan mode |
| irq_clr | input | 1 | Interrupt clear pulse |
| empty | output | 1 | Buffer empty |
| thr_hit | output | 1 | Level at or above threshold |
| full | output | 1 | Level at active depth |
| ovf | output | 1 | Sticky overflow |
| irq | output | 1 | Latched interrupt request |
| busy | output | 1 | Conversion or scan in progress |

## Verification
The overflow flag has two writers that can meet in one cycle. A write into a full buffer sets it, and a read of a non-empty buffer clears it. The bench fills the buffer to its active depth and then raises `wr_valid` and `rd_req` together. `ovf` must still read 1 afterwards while the level drops by one. The same kind of contest exists between an interrupt set event and `irq_clr`. It is provoked by a per-sample write and a clear in the same cycle, and is judged by `irq` staying high. Constrained-random traffic, run against a queue model, also lands on both contests many times.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  localparam int THR_W = 10;

  typedef enum logic [1:0] {
    IRQ_SRC_THRESH = 2'd0,
    IRQ_SRC_SCAN   = 2'd1,
    IRQ_SRC_SAMPLE = 2'd2
  } irq_src_e;

  // threshold register pair -> sample count, bit 0 forced low
  function automatic logic [THR_W-1:0] thr_assemble(input logic hi,
                                                    input logic [THR_W-3:0] lo);
    return {hi, lo, 1'b0};
  endfunction

  function automatic irq_src_e irq_src(input logic fifo_en, input logic scan_en);
    if (fifo_en)      return IRQ_SRC_THRESH;
    else if (scan_en) return IRQ_SRC_SCAN;
    else              return IRQ_SRC_SAMPLE;
  endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter logic [DATA_W-1:0] EMPTY_CODE = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              rd_req,
  input  logic              is_empty,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NWORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NWORDS];
  logic [ADDR_W-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      rd_data <= '0;
    end else begin
      if (rd_req) rd_data <= is_empty ? EMPTY_CODE : mem[rptr_q];
      if (clr) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (push)               wptr_q <= wptr_q + 1'b1;
        if (rd_req && !is_empty) rptr_q <= rptr_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
  parameter int BASE_DEPTH = 512,
  parameter int LVL_W      = 11,
  parameter int THR_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_valid,
  input  logic             rd_req,
  input  logic             enh,
  input  logic [THR_W-1:0] thr,
  output logic [LVL_W-1:0] level,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             is_empty,
  output logic             is_full,
  output logic             at_thr,
  output logic             ovf
);

  localparam logic [LVL_W-1:0] DEPTH_LO = LVL_W'(BASE_DEPTH);
  localparam logic [LVL_W-1:0] DEPTH_HI = LVL_W'(2 * BASE_DEPTH);

  function automatic logic [LVL_W-1:0] active_depth(input logic e);
    return e ? DEPTH_HI : DEPTH_LO;
  endfunction

  logic [LVL_W-1:0] level_q;

  assign level    = level_q;
  assign is_empty = (level_q == '0);
  assign is_full  = (level_q >= active_depth(enh));
  assign at_thr   = !is_empty && (level_q >= LVL_W'(thr));
  assign wr_ok    = wr_valid && !is_full && !clr;
  assign rd_ok    = rd_req && !is_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      ovf     <= 1'b0;
    end else if (clr) begin
      level_q <= '0;
      ovf     <= 1'b0;
    end else begin
      level_q <= level_q + LVL_W'(wr_ok) - LVL_W'(rd_ok);
      if (wr_valid && is_full) ovf <= 1'b1;
      else if (rd_ok)          ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/sfifo_irq_scan.sv
module sfifo_irq_scan #(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              scan_en,
  input  logic              at_thr,
  input  logic              wr_ok,
  input  logic              wr_valid,
  input  logic              conv_start,
  input  logic              conv_busy,
  input  logic [CHAN_W-1:0] lo_chan,
  input  logic [CHAN_W-1:0] hi_chan,
  input  logic              irq_clr,
  output logic              irq,
  output logic              busy,
  output logic              irq_set,
  output logic              scan_done
);
  import sfifo_pkg::*;

  function automatic logic [CHAN_W:0] scan_len(input logic [CHAN_W-1:0] lo,
                                               input logic [CHAN_W-1:0] hi);
    logic [CHAN_W-1:0] span;
    span = hi - lo;
    return {1'b0, span} + (CHAN_W+1)'(1);
  endfunction

  logic              thr_q;
  logic              scan_busy_q;
  logic [CHAN_W:0]   scan_cnt_q;
  logic              thr_rise;

  assign thr_rise  = at_thr && !thr_q;
  assign scan_done = scan_busy_q && wr_valid &&
                     (scan_cnt_q == scan_len(lo_chan, hi_chan) - (CHAN_W+1)'(1));
  assign busy      = scan_en ? scan_busy_q : conv_busy;

  always_comb begin
    case (irq_src(fifo_en, scan_en))
      IRQ_SRC_THRESH: irq_set = thr_rise;
      IRQ_SRC_SCAN:   irq_set = scan_done;
      default:        irq_set = wr_ok;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q       <= 1'b0;
      irq         <= 1'b0;
      scan_busy_q <= 1'b0;
      scan_cnt_q  <= '0;
    end else begin
      thr_q <= at_thr;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (scan_done) begin
        scan_busy_q <= 1'b0;
      end else if (scan_busy_q && wr_valid) begin
        scan_cnt_q <= scan_cnt_q + 1'b1;
      end else if (!scan_busy_q && conv_start && scan_en) begin
        scan_busy_q <= 1'b1;
        scan_cnt_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq #(
  parameter int DATA_W     = 16,
  parameter int BASE_DEPTH = 512,
  parameter int CHAN_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  input  logic              thr_lo_we,
  input  logic              thr_hi_we,
  input  logic [7:0]        thr_wdata,
  input  logic              fifo_en,
  input  logic              scan_en,
  input  logic              enh_mode,
  input  logic              fifo_rst,
  input  logic [CHAN_W-1:0] lo_chan,
  input  logic [CHAN_W-1:0] hi_chan,
  input  logic              conv_start,
  input  logic              conv_busy,
  input  logic              irq_clr,
  output logic              empty,
  output logic              thr_hit,
  output logic              full,
  output logic              ovf,
  output logic              irq,
  output logic              busy
);
  import sfifo_pkg::*;

  localparam int ADDR_W = $clog2(2 * BASE_DEPTH);
  localparam int LVL_W  = ADDR_W + 1;
  localparam logic [DATA_W-1:0] EMPTY_CODE = DATA_W'(8'hFF);

  logic [THR_W-3:0] thr_lo_q;
  logic             thr_hi_q;
  logic [THR_W-1:0] thr;
  logic [LVL_W-1:0] level;
  logic             wr_ok, rd_ok;
  logic             irq_set, scan_done;

  assign thr = thr_assemble(thr_hi_q, thr_lo_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_lo_q <= '0;
      thr_hi_q <= 1'b0;
    end else begin
      if (thr_lo_we) thr_lo_q <= thr_wdata[THR_W-3:0];
      if (thr_hi_we) thr_hi_q <= thr_wdata[0];
    end
  end

  sfifo_level #(.BASE_DEPTH(BASE_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_level (
    .clk(clk), .rst_n(rst_n), .clr(fifo_rst), .wr_valid(wr_valid), .rd_req(rd_req),
    .enh(enh_mode), .thr(thr), .level(level), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .is_empty(empty), .is_full(full), .at_thr(thr_hit), .ovf(ovf)
  );

  sfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EMPTY_CODE(EMPTY_CODE)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_rst), .push(wr_ok), .push_data(wr_data),
    .rd_req(rd_req), .is_empty(empty), .rd_data(rd_data)
  );

  sfifo_irq_scan #(.CHAN_W(CHAN_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .scan_en(scan_en), .at_thr(thr_hit),
    .wr_ok(wr_ok), .wr_valid(wr_valid), .conv_start(conv_start), .conv_busy(conv_busy),
    .lo_chan(lo_chan), .hi_chan(hi_chan), .irq_clr(irq_clr), .irq(irq), .busy(busy),
    .irq_set(irq_set), .scan_done(scan_done)
  );

endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int DATA_W = 16,
  parameter int LVL_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              fifo_en,
  input logic              scan_en,
  input logic              fifo_rst,
  input logic              irq_clr,
  input logic              empty,
  input logic              thr_hit,
  input logic              full,
  input logic              ovf,
  input logic              irq,
  input logic              busy,
  input logic [LVL_W-1:0]  level,
  input logic              irq_set
);

  always_comb begin
    if (rst_n) begin
      assert_thr_needs_data_R1: assert (!(thr_hit && empty));
    end
  end

  assert_empty_read_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> (rd_data == DATA_W'(8'hFF)));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !rd_req && !fifo_rst) |=> $stable(level));

  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !fifo_rst) |=> ovf);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !fifo_rst && !(rd_req && !empty)) |=> ovf);

  assert_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (empty && !full && !thr_hit && !ovf));

  assert_sample_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !scan_en && wr_valid && !full && !fifo_rst) |=> irq);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);

  assert_scan_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && busy && !wr_valid) |=> (busy || !scan_en));

endmodule

bind sample_fifo_irq sfifo_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_req(rd_req), .rd_data(rd_data),
  .fifo_en(fifo_en), .scan_en(scan_en), .fifo_rst(fifo_rst), .irq_clr(irq_clr),
  .empty(empty), .thr_hit(thr_hit), .full(full), .ovf(ovf), .irq(irq), .busy(busy),
  .level(level), .irq_set(irq_set)
);

// File: tb/sim_sample_fifo_irq.sv
`timescale 1ns/1ps
module sim_sample_fifo_irq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, rd_req = 0, thr_lo_we = 0, thr_hi_we = 0;
  logic [15:0] wr_data = 0;
  logic [7:0]  thr_wdata = 0;
  logic fifo_en = 0, scan_en = 0, enh_mode = 0, fifo_rst = 0;
  logic [4:0] lo_chan = 0, hi_chan = 0;
  logic conv_start = 0, conv_busy = 0, irq_clr = 0;
  logic [15:0] rd_data;
  logic empty, thr_hit, full, ovf, irq, busy;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sample_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .thr_lo_we(thr_lo_we), .thr_hi_we(thr_hi_we), .thr_wdata(thr_wdata),
    .fifo_en(fifo_en), .scan_en(scan_en), .enh_mode(enh_mode), .fifo_rst(fifo_rst),
    .lo_chan(lo_chan), .hi_chan(hi_chan), .conv_start(conv_start), .conv_busy(conv_busy),
    .irq_clr(irq_clr), .empty(empty), .thr_hit(thr_hit), .full(full), .ovf(ovf),
    .irq(irq), .busy(busy)
  );

  // ---------------- reference model ----------------
  logic [15:0] mq[$];
  logic [9:0]  m_thr;
  logic m_ovf, m_irq, m_tfq, m_busy, m_rdv;
  int   m_cnt;
  logic [15:0] m_rd;

  function automatic int depth_of(logic e);
    return e ? 1024 : 512;
  endfunction
  function automatic logic tf_of(int lvl, logic [9:0] t);
    return (lvl != 0) && (lvl >= int'(t));
  endfunction
  function automatic int span_of(logic [4:0] lo, logic [4:0] hi);
    return ((int'(hi) - int'(lo)) & 31) + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_thr = 0; m_ovf = 0; m_irq = 0; m_tfq = 0;
      m_busy = 0; m_cnt = 0; m_rdv = 0; m_rd = 0;
    end else begin
      int lvl; logic mfull, mempty, tf, wok, done, ev;
      lvl = mq.size();
      mfull = lvl >= depth_of(enh_mode);
      mempty = lvl == 0;
      tf = tf_of(lvl, m_thr);
      wok = wr_valid && !mfull && !fifo_rst;
      done = m_busy && wr_valid && (m_cnt == span_of(lo_chan, hi_chan) - 1);
      ev = fifo_en ? (tf && !m_tfq) : (scan_en ? done : wok);
      m_tfq = tf;
      m_rdv = rd_req;
      if (rd_req) m_rd = mempty ? 16'h00FF : mq.pop_front();
      if (fifo_rst) begin mq.delete(); m_ovf = 0; end
      else begin
        if (wr_valid && mfull) m_ovf = 1;
        else if (rd_req && !mempty) m_ovf = 0;
        if (wok) mq.push_back(wr_data);
      end
      if (thr_lo_we) m_thr[8:1] = thr_wdata;
      if (thr_hi_we) m_thr[9] = thr_wdata[0];
      if (ev) m_irq = 1; else if (irq_clr) m_irq = 0;
      if (done) m_busy = 0;
      else if (m_busy && wr_valid) m_cnt++;
      else if (!m_busy && conv_start && scan_en) begin m_busy = 1; m_cnt = 0; end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int lvl;
      lvl = mq.size();
      check("R2 empty flag", empty, lvl == 0);
      check("R4 R6 full flag", full, lvl >= depth_of(enh_mode));
      check("R1 threshold flag", thr_hit, tf_of(lvl, m_thr));
      check("R5 overflow flag", ovf, m_ovf);
      check("R8 R9 R10 irq", irq, m_irq);
      check("R11 busy", busy, scan_en ? m_busy : conv_busy);
      if (m_rdv) check("R3 R2 read data", rd_data, m_rd);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask
  task automatic idle();
    wr_valid = 0; rd_req = 0; thr_lo_we = 0; thr_hi_we = 0;
    fifo_rst = 0; conv_start = 0; irq_clr = 0;
  endtask
  task automatic set_thr(input logic [9:0] t);
    thr_wdata = t[8:1]; thr_lo_we = 1; tick(); thr_lo_we = 0;
    thr_wdata = {7'd0, t[9]}; thr_hi_we = 1; tick(); thr_hi_we = 0;
  endtask
  task automatic clear_all();
    fifo_rst = 1; irq_clr = 1; tick(); idle(); irq_clr = 1; tick(); idle();
  endtask
  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = 16'($urandom); tick();
    end
    wr_valid = 0;
  endtask

  initial begin
    void'($urandom(32'h5A17C3E1));
    repeat (3) tick();
    check("R7 reset empty", empty, 1);
    rst_n = 1;
    tick();
    check("R7 reset flags", {full, thr_hit, ovf, irq}, 4'b0000);

    // constrained random phases
    for (int ph = 0; ph < 6; ph++) begin
      int wp, rp;
      wp = (ph % 2 == 0) ? 85 : 40;
      rp = (ph % 2 == 0) ? 20 : 60;
      fifo_en = ph[0]; scan_en = (ph == 2) || (ph == 5); enh_mode = ph[1];
      lo_chan = 5'($urandom); hi_chan = 5'($urandom);
      for (int c = 0; c < 1500; c++) begin
        wr_valid   = ($urandom % 100) < wp;
        wr_data    = 16'($urandom);
        rd_req     = ($urandom % 100) < rp;
        thr_lo_we  = ($urandom % 100) < 2;
        thr_hi_we  = ($urandom % 100) < 1;
        thr_wdata  = 8'($urandom);
        irq_clr    = ($urandom % 100) < 10;
        fifo_rst   = ($urandom % 1000) < 2;
        conv_start = ($urandom % 100) < 5;
        conv_busy  = 1'($urandom);
        tick();
      end
      idle();
    end

    // directed: fill to 512, overflow, collision of overflow with read
    fifo_en = 0; scan_en = 0; enh_mode = 0; conv_busy = 0;
    clear_all();
    check("R7 clear flags", {empty, thr_hit, full, ovf}, 4'b1000);
    set_thr(10'd0);
    push_n(512);
    check("R4 R6 full at 512", full, 1);
    wr_valid = 1; wr_data = 16'hDEAD; tick(); wr_valid = 0;
    check("R5 overflow set", ovf, 1);
    wr_valid = 1; rd_req = 1; tick(); idle();
    check("R5 overflow kept on same-cycle read", ovf, 1);
    check("R4 level after dropped write and read", full, 0);
    enh_mode = 1; tick();
    check("R6 extended depth not full", full, 0);
    rd_req = 1; tick(); rd_req = 0;
    check("R5 overflow cleared by good read", ovf, 0);
    enh_mode = 0;

    // directed: reset with simultaneous write, then empty read
    fifo_rst = 1; wr_valid = 1; tick(); idle();
    check("R7 write dropped with clear", empty, 1);
    rd_req = 1; tick(); rd_req = 0;
    check("R2 empty read code", rd_data, 16'h00FF);

    // directed: threshold interrupt, thr = 4
    fifo_en = 1; set_thr(10'd4); clear_all();
    push_n(3);
    check("R1 below threshold", thr_hit, 0);
    wr_valid = 1; tick(); wr_valid = 0;
    check("R1 at threshold", thr_hit, 1);
    check("R8 irq not yet", irq, 0);
    tick();
    check("R8 irq after threshold", irq, 1);

    // directed: irq set and clear in same cycle
    fifo_en = 0; scan_en = 0; clear_all();
    wr_valid = 1; irq_clr = 1; tick(); idle();
    check("R10 set beats clear", irq, 1);
    tick();
    check("R10 irq held", irq, 1);
    irq_clr = 1; tick(); idle();
    check("R10 irq cleared", irq, 0);

    // directed: scan of channels 3..6
    scan_en = 1; lo_chan = 5'd3; hi_chan = 5'd6; clear_all();
    conv_start = 1; tick(); conv_start = 0;
    check("R11 scan busy", busy, 1);
    push_n(3);
    check("R11 busy mid scan", busy, 1);
    check("R9 no irq mid scan", irq, 0);
    push_n(1);
    check("R11 busy end of scan", busy, 0);
    check("R9 irq end of scan", irq, 1);
    scan_en = 0; conv_busy = 1; tick();
    check("R11 passthrough", busy, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule